// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Front End

This block sits at the serial port of a flash memory slave. It decodes the first byte of every chip-select frame and keeps the single bit that gives permission to change the array or the configuration. The write-enable command sets that bit and the write-disable command clears it. Program, erase and configuration-write commands are passed to the memory core only when the bit is already set. When the core reports that such an operation has finished, the bit clears itself, so each modifying operation needs a fresh write-enable.

All serial inputs are sampled on the system clock `clk`. They are expected to be synchronous to it already, and the serial clock must stay at each level for at least one `clk` period. A modifying command is passed on as a one-cycle `op_start` pulse together with an operation code. The block then reports busy until the core returns `op_done`. The latch and busy flag can be read in parallel on `status`, or shifted out serially with a read-status command. During that command the block enables its serial output driver through `miso_oe`. The address and data bytes that follow a modifying opcode belong to the core and are not interpreted here.

Top module: `spiwel_front`

## Requirements
- R1: After reset, `status` is 0 (latch clear, not busy), `op_start` is low and `miso_oe` is low.
- R2: Opcode bits are taken from `mosi` on rising serial-clock edges while `cs_n` is low, most significant bit first. A frame of exactly 8 bits carrying 0x06 sets the latch, which is `status` bit 1, once `cs_n` rises.
- R3: A frame of exactly 8 bits carrying 0x04 clears the latch once `cs_n` rises.
- R4: A 0x06 or 0x04 frame that ends with any bit count other than 8 leaves the latch unchanged.
- R5: A frame of 8 or more bits whose first byte is 0x02 (program), 0xD8 (sector erase), 0xC7 (bulk erase) or 0x01 (status write), ended while the latch is set, produces a one-cycle `op_start`. It drives `op_code` to 1, 2, 3 or 4 respectively and sets busy (`status` bit 0). `op_code` holds while busy.
- R6: A modifying frame that ends while the latch is clear, or after fewer than 8 bits, starts nothing and changes no state.
- R7: `op_done` while busy clears both busy and the latch. `op_done` while idle has no effect.
- R8: While busy, every frame except read-status is ignored. No new operation starts and the latch is not changed.
- R9: After the 8th bit of a 0x05 frame, `miso_oe` is high until `cs_n` rises. `miso` presents a snapshot of `status` taken at that bit, MSB first, with each bit valid before the rising serial-clock edge that reads it. The byte repeats for as long as the frame continues. Bit 1 of the snapshot is the latch, bit 0 is busy and the rest are 0.
- R10: `miso_oe` is low whenever `cs_n` is high and during every frame other than read-status.
- R11: A complete frame with any other opcode, such as 0xAB, has no effect on the latch and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, frames a command |
| sck | input | 1 | Serial clock, sampled on `clk` |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the serial data out pad |
| op_start | output | 1 | One-cycle request to the memory core |
| op_code | output | 3 | Operation requested: 1 program, 2 sector erase, 3 bulk erase, 4 status write |
| op_done | input | 1 | Completion pulse from the memory core |
| status | output | 8 | Bit 1 latch, bit 0 busy, other bits 0 |

## Verification
The decode is driven with frames whose bit count falls short of a byte, equals a byte exactly, or runs past a byte. These frames show whether the enable and disable commands need an exact byte while the modifying commands accept trailing bytes. Every modifying opcode is sent once with the latch set and once with it clear. This shows the gating, the operation code mapping and the automatic clear on completion. An unknown opcode and a completion pulse that arrives while idle confirm that neither has any effect. Frames sent while the core is held busy, including a read-status frame, separate commands that are refused from the read that is still served.

// File: rtl/spiwel_pkg.sv
package spiwel_pkg;
    localparam int CMD_W = 8;
    localparam int CNT_W = $clog2(CMD_W + 2);

    localparam logic [CMD_W-1:0] OPC_WR_EN  = 8'h06;
    localparam logic [CMD_W-1:0] OPC_WR_DIS = 8'h04;
    localparam logic [CMD_W-1:0] OPC_PROG   = 8'h02;
    localparam logic [CMD_W-1:0] OPC_SECT   = 8'hD8;
    localparam logic [CMD_W-1:0] OPC_BULK   = 8'hC7;
    localparam logic [CMD_W-1:0] OPC_WSTAT  = 8'h01;
    localparam logic [CMD_W-1:0] OPC_RSTAT  = 8'h05;

    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_SECT  = 3'd2,
        OP_BULK  = 3'd3,
        OP_WSTAT = 3'd4
    } op_e;
endpackage

// File: rtl/spiwel_shift.sv
module spiwel_shift
    import spiwel_pkg::*;
#(
    parameter int W  = CMD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    output logic          sck_rise,
    output logic          cs_rise,
    output logic          byte_done,
    output logic [W-1:0]  byte_val,
    output logic [CW-1:0] bit_cnt,
    output logic [W-1:0]  opcode
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] SAT  = CW'(W + 1);

    typedef struct packed {
        logic          sck;
        logic          csn;
        logic [W-2:0]  sr;
        logic [CW-1:0] cnt;
        logic [W-1:0]  opc;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [W-1:0] shifted;

    always_comb begin
        sh_d      = sh_q;
        sh_d.sck  = sck;
        sh_d.csn  = cs_n;
        sck_rise  = sck & ~sh_q.sck & ~cs_n;
        cs_rise   = cs_n & ~sh_q.csn;
        shifted   = {sh_q.sr, mosi};
        byte_done = sck_rise && (sh_q.cnt == LAST);
        if (cs_n) begin
            sh_d.cnt = '0;
        end else if (sck_rise) begin
            sh_d.sr = shifted[W-2:0];
            if (sh_q.cnt != SAT) sh_d.cnt = sh_q.cnt + 1'b1;
            if (byte_done) sh_d.opc = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '{csn: 1'b1, default: '0};
        else        sh_q <= sh_d;
    end

    assign byte_val = shifted;
    assign bit_cnt  = sh_q.cnt;
    assign opcode   = sh_q.opc;
endmodule

// File: rtl/spiwel_ctrl.sv
module spiwel_ctrl
    import spiwel_pkg::*;
#(
    parameter int W  = CMD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_rise,
    input  logic [CW-1:0] bit_cnt,
    input  logic [W-1:0]  opcode,
    input  logic          op_done,
    output logic          op_start,
    output op_e           op_code,
    output logic          wel,
    output logic          busy
);
    localparam logic [CW-1:0] FULL = CW'(W);

    typedef struct packed {
        logic wel;
        logic busy;
        logic start;
        op_e  code;
    } ct_t;

    ct_t  ct_d, ct_q;
    logic exact_byte;
    logic whole_byte;
    op_e  mod_op;

    function automatic op_e map_op(input logic [W-1:0] c);
        case (c)
            OPC_PROG:  return OP_PROG;
            OPC_SECT:  return OP_SECT;
            OPC_BULK:  return OP_BULK;
            OPC_WSTAT: return OP_WSTAT;
            default:   return OP_NONE;
        endcase
    endfunction

    always_comb begin
        ct_d       = ct_q;
        ct_d.start = 1'b0;
        exact_byte = (bit_cnt == FULL);
        whole_byte = (bit_cnt >= FULL);
        mod_op     = map_op(opcode);
        if (ct_q.busy) begin
            if (op_done) begin
                ct_d.busy = 1'b0;
                ct_d.wel  = 1'b0;
            end
        end else if (cs_rise) begin
            if (exact_byte && opcode == OPC_WR_EN) begin
                ct_d.wel = 1'b1;
            end else if (exact_byte && opcode == OPC_WR_DIS) begin
                ct_d.wel = 1'b0;
            end else if (whole_byte && mod_op != OP_NONE && ct_q.wel) begin
                ct_d.start = 1'b1;
                ct_d.busy  = 1'b1;
                ct_d.code  = mod_op;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ct_q <= '{code: OP_NONE, default: '0};
        else        ct_q <= ct_d;
    end

    assign op_start = ct_q.start;
    assign op_code  = ct_q.code;
    assign wel      = ct_q.wel;
    assign busy     = ct_q.busy;
endmodule

// File: rtl/spiwel_sout.sv
module spiwel_sout
    import spiwel_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sck_rise,
    input  logic         byte_done,
    input  logic [W-1:0] byte_val,
    input  logic [W-1:0] stat,
    output logic         miso,
    output logic         miso_oe
);
    typedef struct packed {
        logic         act;
        logic [W-1:0] sr;
    } so_t;

    so_t so_d, so_q;

    always_comb begin
        so_d = so_q;
        if (cs_n) begin
            so_d.act = 1'b0;
        end else if (byte_done) begin
            if (byte_val == OPC_RSTAT) begin
                so_d.act = 1'b1;
                so_d.sr  = stat;
            end
        end else if (sck_rise && so_q.act) begin
            so_d.sr = {so_q.sr[W-2:0], so_q.sr[W-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) so_q <= '0;
        else        so_q <= so_d;
    end

    assign miso    = so_q.act & so_q.sr[W-1];
    assign miso_oe = so_q.act & ~cs_n;
endmodule

// File: rtl/spiwel_front.sv
module spiwel_front
    import spiwel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic       miso_oe,
    output logic       op_start,
    output logic [2:0] op_code,
    input  logic       op_done,
    output logic [7:0] status
);
    logic             sck_rise, cs_rise, byte_done;
    logic [CMD_W-1:0] byte_val, opcode;
    logic [CNT_W-1:0] bit_cnt;
    logic             wel, busy;
    op_e              code;
    logic [CMD_W-1:0] stat;

    spiwel_shift #(.W(CMD_W), .CW(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .sck_rise(sck_rise), .cs_rise(cs_rise), .byte_done(byte_done),
        .byte_val(byte_val), .bit_cnt(bit_cnt), .opcode(opcode)
    );

    spiwel_ctrl #(.W(CMD_W), .CW(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
        .opcode(opcode), .op_done(op_done), .op_start(op_start),
        .op_code(code), .wel(wel), .busy(busy)
    );

    always_comb begin
        stat          = '0;
        stat[ST_WEL]  = wel;
        stat[ST_BUSY] = busy;
    end

    spiwel_sout #(.W(CMD_W)) u_sout (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
        .byte_done(byte_done), .byte_val(byte_val), .stat(stat),
        .miso(miso), .miso_oe(miso_oe)
    );

    assign op_code = code;
    assign status  = stat;
endmodule

// File: rtl/spiwel_front_chk.sv
module spiwel_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       op_start,
    input logic [2:0] op_code,
    input logic       op_done,
    input logic       wel,
    input logic       busy
);
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_code));

    p_start_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wel));

    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> (!busy && !wel));

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !op_start);

    p_wel_at_cs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(cs_n) && !$past(cs_n, 2)));
endmodule

bind spiwel_front spiwel_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_start(op_start),
    .op_code(op_code), .op_done(op_done), .wel(status[1]), .busy(status[0])
);

// File: tb/spiwel_front_test.sv
module spiwel_front_test;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] nbits;
        logic       wel;
        logic       start;
        logic [2:0] code;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'h06, 8'd8,  1'b1, 1'b0, 3'd0},  // R2 set
        '{8'h02, 8'd8,  1'b0, 1'b1, 3'd1},  // R5 program, R7 auto clear
        '{8'h02, 8'd8,  1'b0, 1'b0, 3'd0},  // R6 latch clear
        '{8'h06, 8'd8,  1'b1, 1'b0, 3'd0},  // R2
        '{8'h04, 8'd8,  1'b0, 1'b0, 3'd0},  // R3 clear
        '{8'h06, 8'd7,  1'b0, 1'b0, 3'd0},  // R4 short enable
        '{8'h06, 8'd8,  1'b1, 1'b0, 3'd0},  // R2
        '{8'h04, 8'd9,  1'b1, 1'b0, 3'd0},  // R4 long disable
        '{8'hD8, 8'd32, 1'b0, 1'b1, 3'd2},  // R5 sector erase
        '{8'h06, 8'd8,  1'b1, 1'b0, 3'd0},
        '{8'hC7, 8'd8,  1'b0, 1'b1, 3'd3},  // R5 bulk erase
        '{8'h06, 8'd8,  1'b1, 1'b0, 3'd0},
        '{8'h01, 8'd16, 1'b0, 1'b1, 3'd4},  // R5 status write
        '{8'h06, 8'd8,  1'b1, 1'b0, 3'd0},
        '{8'hAB, 8'd8,  1'b1, 1'b0, 3'd0},  // R11 unknown
        '{8'h02, 8'd7,  1'b1, 1'b0, 3'd0},  // R6 short program
        '{8'h04, 8'd8,  1'b0, 1'b0, 3'd0}   // R3
    };

    logic       clk = 1'b0;
    logic       rst_n, cs_n, sck, mosi;
    logic       miso, miso_oe, op_start, op_done;
    logic [2:0] op_code;
    logic [7:0] status;

    logic stub_en, stub_done, man_done, rd_window;
    int   stub_cnt;
    int   starts, oe_bad;
    logic [2:0] last_code;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;

    assign op_done = stub_done | man_done;

    spiwel_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .op_start(op_start),
        .op_code(op_code), .op_done(op_done), .status(status)
    );

    always #(CLK_P / 2) clk = ~clk;

    // core stub: completes an operation a few cycles after its start
    always @(negedge clk) begin
        if (!rst_n) begin
            stub_cnt  = 0;
            stub_done = 1'b0;
        end else begin
            stub_done = 1'b0;
            if (op_start && stub_en) stub_cnt = 4;
            else if (stub_cnt > 0) begin
                stub_cnt = stub_cnt - 1;
                if (stub_cnt == 0) stub_done = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && op_start) begin
            starts    = starts + 1;
            last_code = op_code;
        end
        if (miso_oe && !rd_window) oe_bad = oe_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic bit_xfer(input logic b, output logic o);
        @(negedge clk);
        mosi = b;
        o    = miso;
        @(negedge clk) sck = 1'b1;
        @(negedge clk);
        @(negedge clk) sck = 1'b0;
    endtask

    task automatic frame(input logic [7:0] opc, input int nbits);
        logic o;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nbits; i++)
            bit_xfer((i < 8) ? opc[7 - i] : 1'b0, o);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int w = 0; w < 50 && status[0]; w++) @(negedge clk);
    endtask

    task automatic read_stat(input logic [7:0] exp);
        logic o;
        logic [7:0] got;
        rd_window = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < 8; i++) bit_xfer(spiwel_pkg::OPC_RSTAT[7 - i], o);
        for (int r = 0; r < 2; r++) begin
            got = '0;
            for (int i = 0; i < 8; i++) begin
                bit_xfer(1'b0, o);
                got[7 - i] = o;
                chk(miso_oe === 1'b1, "R9 oe during read", int'(miso_oe), 1);
            end
            chk(got === exp, "R9 status byte", int'(got), int'(exp));
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk(miso_oe === 1'b0, "R10 oe after cs high", int'(miso_oe), 0);
        rd_window = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int s0;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        man_done = 1'b0; stub_en = 1'b1; rd_window = 1'b0;
        starts = 0; oe_bad = 0; last_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status === 8'h00, "R1 status", int'(status), 0);
        chk(op_start === 1'b0, "R1 op_start", int'(op_start), 0);
        chk(miso_oe === 1'b0, "R1 miso_oe", int'(miso_oe), 0);

        // vector walk: R2 R3 R4 R5 R6 R7 R11
        for (int k = 0; k < NV; k++) begin
            s0 = starts;
            frame(VECS[k].opc, int'(VECS[k].nbits));
            wait_idle();
            chk(status[1] === VECS[k].wel, $sformatf("R2/R3/R4/R6/R7/R11 latch vec %0d", k),
                int'(status[1]), int'(VECS[k].wel));
            chk((starts - s0) == int'(VECS[k].start), $sformatf("R5/R6 starts vec %0d", k),
                starts - s0, int'(VECS[k].start));
            if (VECS[k].start)
                chk(last_code === VECS[k].code, $sformatf("R5 op_code vec %0d", k),
                    int'(last_code), int'(VECS[k].code));
            chk(status[0] === 1'b0, $sformatf("R7 busy cleared vec %0d", k), int'(status[0]), 0);
        end

        // R9 read status with latch set
        frame(8'h06, 8);
        read_stat(8'h02);

        // R7 completion while idle has no effect
        @(negedge clk) man_done = 1'b1;
        @(negedge clk) man_done = 1'b0;
        @(negedge clk);
        chk(status === 8'h02, "R7 idle done ignored", int'(status), 2);

        // R8 busy blocks commands
        stub_en = 1'b0;
        s0 = starts;
        frame(8'h02, 8);
        chk(status === 8'h03, "R5 busy set", int'(status), 3);
        read_stat(8'h03);
        frame(8'h04, 8);
        chk(status[1] === 1'b1, "R8 disable ignored while busy", int'(status[1]), 1);
        frame(8'hD8, 8);
        chk((starts - s0) == 1, "R8 no second start", starts - s0, 1);
        chk(op_code === 3'd1, "R5 op_code held while busy", int'(op_code), 1);
        @(negedge clk) man_done = 1'b1;
        @(negedge clk) man_done = 1'b0;
        @(negedge clk);
        chk(status === 8'h00, "R7 done clears latch and busy", int'(status), 0);
        stub_en = 1'b1;

        // R9 read status when everything clear
        read_stat(8'h00);

        // R1 reset clears a set latch
        frame(8'h06, 8);
        chk(status[1] === 1'b1, "R2 latch set before reset", int'(status[1]), 1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(status === 8'h00, "R1 reset clears latch", int'(status), 0);

        chk(oe_bad == 0, "R10 oe outside read frames", oe_bad, 0);
        finish_up();
    end
endmodule